// File: doc/BRIEF.md
# Instruction Prefetch Register Pair

This block is the two-register front end of a microcoded processor's instruction path. A next-instruction register captures a 16-bit word arriving from main memory while a current-instruction register holds the instruction under execution. Fetching one instruction can therefore overlap the execution of the one before it. Microcode field codes decide when each register moves. A memory-control code or the skip code "advance" loads the next register. The skip code "advance" moves the next register into the current register. A special code also moves it, one clock after the code is seen.

A valid bit records whether the next register holds a word that has not yet been consumed. A transfer can coincide with a fresh memory load while the pipeline is empty, either because an external empty flag is raised or because the valid bit is clear. In that case the incoming word goes straight into the current register and, in the same cycle, onto the operand multiplexer output. This saves one clock.

A translation-source flag tells downstream translation logic where to read. It reads the current register once two cycles have passed since the last transfer. For a right-hand stack-op it reads the current register at all times.

Top module: `insn_prefetch_pair`

## Requirements
- R1: After reset, cur_insn_o and nxt_insn_o are zero, nxt_full_o is 0 and xlat_cur_o is 1.
- R2: nxt_insn_o takes mem_word_i at a clock edge when mem_valid_i is 1 and either skip_code_i equals 3'd5 (advance) or mctl_code_i equals 3'd2 (fetch-next). Otherwise nxt_insn_o holds, except as stated in R6.
- R3: A transfer occurs at an edge when skip_code_i equals 3'd5 or a delayed special transfer is pending. Outside the fill case, cur_insn_o then takes the value nxt_insn_o had before that edge.
- R4: When spec_code_i equals 5'd9 in one cycle, a transfer happens at the following edge rather than the one ending that cycle.
- R5: When a load (R2) and a transfer (R3) fall in the same cycle outside the fill case, cur_insn_o gets the old next word, nxt_insn_o gets the new memory word, and nxt_full_o is 1.
- R6: Fill case: a transfer coincides with a load while pipe_empty_i is 1 or nxt_full_o is 0. In that cycle fill_o is 1 and opnd_o equals mem_word_i. At the edge, both registers take mem_word_i and nxt_full_o clears.
- R7: When fill_o is 0, opnd_o equals cur_insn_o.
- R8: nxt_full_o sets on a load without a transfer and clears on a transfer without a load.
- R9: xlat_cur_o is 1 when right_op_i is 1 or when at least two edges have passed since the last transfer. It is 0 otherwise.
- R10: Skip, memory-control and special codes other than 3'd5, 3'd2 and 5'd9 change no register. A load code without mem_valid_i changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_word_i | input | 16 | Instruction word from main memory |
| mem_valid_i | input | 1 | Memory word present this cycle |
| skip_code_i | input | 3 | Microcode skip field |
| spec_code_i | input | 5 | Microcode special field |
| mctl_code_i | input | 3 | Microcode memory-control field |
| pipe_empty_i | input | 1 | Prefetch pipeline not yet filled |
| right_op_i | input | 1 | Current instruction is a right-hand stack-op |
| cur_insn_o | output | 16 | Current-instruction register |
| nxt_insn_o | output | 16 | Next-instruction register |
| opnd_o | output | 16 | Word presented to the operand multiplexer |
| fill_o | output | 1 | Fill bypass active this cycle |
| nxt_full_o | output | 1 | Next register holds an unconsumed word |
| xlat_cur_o | output | 1 | Translation reads the current register |

## Verification
The bench builds the block with its default parameters: 16-bit words, 3-bit skip and memory-control fields, a 5-bit special field and a translation delay of two. With only eight skip and memory-control codes, biased random draws land on the advance and fetch-next codes often. Coincident load and transfer, back-to-back special codes and fill cycles therefore all occur frequently. The short delay means the translation flag covers both its low and saturated states within a few cycles of each transfer.

// File: rtl/ipf_pkg.sv
package ipf_pkg;
    localparam int unsigned WORD_W_DEF    = 16;
    localparam int unsigned FIELD_W_DEF   = 3;
    localparam int unsigned SPEC_W_DEF    = 5;
    localparam int unsigned XLAT_DLY_DEF  = 2;

    // saturating increment used by the execution-age counter
    function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
        return (v < lim) ? v + 1 : lim;
    endfunction
endpackage

// File: rtl/ipf_decode.sv
module ipf_decode #(
    parameter int unsigned     FIELD_W = ipf_pkg::FIELD_W_DEF,
    parameter int unsigned     SPEC_W  = ipf_pkg::SPEC_W_DEF,
    parameter logic [FIELD_W-1:0] CODE_ADV  = 3'd5,
    parameter logic [FIELD_W-1:0] CODE_FNXT = 3'd2,
    parameter logic [SPEC_W-1:0]  CODE_DXFR = 5'd9
) (
    input  logic               mem_valid_i,
    input  logic [FIELD_W-1:0] skip_code_i,
    input  logic [FIELD_W-1:0] mctl_code_i,
    input  logic [SPEC_W-1:0]  spec_code_i,
    output logic               load_o,
    output logic               adv_o,
    output logic               dxfr_o
);
    always_comb begin
        adv_o  = (skip_code_i == CODE_ADV);
        load_o = mem_valid_i && (adv_o || (mctl_code_i == CODE_FNXT));
        dxfr_o = (spec_code_i == CODE_DXFR);
    end
endmodule

// File: rtl/ipf_regs.sv
module ipf_regs #(
    parameter int unsigned WORD_W   = ipf_pkg::WORD_W_DEF,
    parameter int unsigned XLAT_DLY = ipf_pkg::XLAT_DLY_DEF,
    localparam int unsigned AGE_W   = $clog2(XLAT_DLY + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [WORD_W-1:0] mem_word_i,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic              dxfr_i,
    input  logic              pipe_empty_i,
    output logic [WORD_W-1:0] cur_o,
    output logic [WORD_W-1:0] nxt_o,
    output logic              full_o,
    output logic              fill_o,
    output logic [AGE_W-1:0]  age_o
);
    typedef struct packed {
        logic [WORD_W-1:0] cur;
        logic [WORD_W-1:0] nxt;
        logic              full;
        logic              pend;
        logic [AGE_W-1:0]  age;
    } pair_state_t;

    localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(XLAT_DLY);

    pair_state_t st_q, st_d;
    logic        xfer;
    logic        fill;

    always_comb begin
        st_d      = st_q;
        xfer      = adv_i || st_q.pend;
        fill      = xfer && load_i && (pipe_empty_i || !st_q.full);
        st_d.pend = dxfr_i;

        if (fill) begin
            st_d.cur  = mem_word_i;
            st_d.nxt  = mem_word_i;
            st_d.full = 1'b0;
        end else begin
            if (xfer) begin
                st_d.cur  = st_q.nxt;
                st_d.full = 1'b0;
            end
            if (load_i) begin
                st_d.nxt  = mem_word_i;
                st_d.full = 1'b1;
            end
        end

        if (xfer) begin
            st_d.age = '0;
        end else begin
            st_d.age = AGE_W'(ipf_pkg::sat_inc(int'(st_q.age), XLAT_DLY));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cur  <= '0;
            st_q.nxt  <= '0;
            st_q.full <= 1'b0;
            st_q.pend <= 1'b0;
            st_q.age  <= AGE_SAT;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_o  = st_q.cur;
    assign nxt_o  = st_q.nxt;
    assign full_o = st_q.full;
    assign fill_o = fill;
    assign age_o  = st_q.age;
endmodule

// File: rtl/ipf_outsel.sv
module ipf_outsel #(
    parameter int unsigned WORD_W   = ipf_pkg::WORD_W_DEF,
    parameter int unsigned XLAT_DLY = ipf_pkg::XLAT_DLY_DEF,
    localparam int unsigned AGE_W   = $clog2(XLAT_DLY + 1)
) (
    input  logic              fill_i,
    input  logic [WORD_W-1:0] mem_word_i,
    input  logic [WORD_W-1:0] cur_i,
    input  logic [AGE_W-1:0]  age_i,
    input  logic              right_op_i,
    output logic [WORD_W-1:0] opnd_o,
    output logic              xlat_cur_o
);
    always_comb begin
        opnd_o     = fill_i ? mem_word_i : cur_i;
        xlat_cur_o = right_op_i || (age_i >= AGE_W'(XLAT_DLY));
    end
endmodule

// File: rtl/insn_prefetch_pair.sv
module insn_prefetch_pair #(
    parameter int unsigned WORD_W   = ipf_pkg::WORD_W_DEF,
    parameter int unsigned FIELD_W  = ipf_pkg::FIELD_W_DEF,
    parameter int unsigned SPEC_W   = ipf_pkg::SPEC_W_DEF,
    parameter int unsigned XLAT_DLY = ipf_pkg::XLAT_DLY_DEF,
    parameter logic [FIELD_W-1:0] CODE_ADV  = 3'd5,
    parameter logic [FIELD_W-1:0] CODE_FNXT = 3'd2,
    parameter logic [SPEC_W-1:0]  CODE_DXFR = 5'd9
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [WORD_W-1:0]  mem_word_i,
    input  logic               mem_valid_i,
    input  logic [FIELD_W-1:0] skip_code_i,
    input  logic [SPEC_W-1:0]  spec_code_i,
    input  logic [FIELD_W-1:0] mctl_code_i,
    input  logic               pipe_empty_i,
    input  logic               right_op_i,
    output logic [WORD_W-1:0]  cur_insn_o,
    output logic [WORD_W-1:0]  nxt_insn_o,
    output logic [WORD_W-1:0]  opnd_o,
    output logic               fill_o,
    output logic               nxt_full_o,
    output logic               xlat_cur_o
);
    localparam int unsigned AGE_W = $clog2(XLAT_DLY + 1);

    logic             load_w, adv_w, dxfr_w;
    logic [AGE_W-1:0] age_w;

    ipf_decode #(
        .FIELD_W(FIELD_W), .SPEC_W(SPEC_W),
        .CODE_ADV(CODE_ADV), .CODE_FNXT(CODE_FNXT), .CODE_DXFR(CODE_DXFR)
    ) u_dec (
        .mem_valid_i (mem_valid_i),
        .skip_code_i (skip_code_i),
        .mctl_code_i (mctl_code_i),
        .spec_code_i (spec_code_i),
        .load_o      (load_w),
        .adv_o       (adv_w),
        .dxfr_o      (dxfr_w)
    );

    ipf_regs #(.WORD_W(WORD_W), .XLAT_DLY(XLAT_DLY)) u_regs (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .mem_word_i   (mem_word_i),
        .load_i       (load_w),
        .adv_i        (adv_w),
        .dxfr_i       (dxfr_w),
        .pipe_empty_i (pipe_empty_i),
        .cur_o        (cur_insn_o),
        .nxt_o        (nxt_insn_o),
        .full_o       (nxt_full_o),
        .fill_o       (fill_o),
        .age_o        (age_w)
    );

    ipf_outsel #(.WORD_W(WORD_W), .XLAT_DLY(XLAT_DLY)) u_out (
        .fill_i     (fill_o),
        .mem_word_i (mem_word_i),
        .cur_i      (cur_insn_o),
        .age_i      (age_w),
        .right_op_i (right_op_i),
        .opnd_o     (opnd_o),
        .xlat_cur_o (xlat_cur_o)
    );
endmodule

// File: rtl/ipf_checker.sv
module ipf_checker #(
    parameter int unsigned WORD_W  = 16,
    parameter int unsigned FIELD_W = 3,
    parameter int unsigned SPEC_W  = 5,
    parameter logic [FIELD_W-1:0] CODE_ADV  = 3'd5,
    parameter logic [FIELD_W-1:0] CODE_FNXT = 3'd2,
    parameter logic [SPEC_W-1:0]  CODE_DXFR = 5'd9
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [WORD_W-1:0]  mem_word_i,
    input logic               mem_valid_i,
    input logic [FIELD_W-1:0] skip_code_i,
    input logic [SPEC_W-1:0]  spec_code_i,
    input logic [FIELD_W-1:0] mctl_code_i,
    input logic               right_op_i,
    input logic [WORD_W-1:0]  cur_insn_o,
    input logic [WORD_W-1:0]  nxt_insn_o,
    input logic [WORD_W-1:0]  opnd_o,
    input logic               fill_o,
    input logic               nxt_full_o,
    input logic               xlat_cur_o
);
    AST_NXT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mem_valid_i || (skip_code_i != CODE_ADV && mctl_code_i != CODE_FNXT)) && !fill_o
        |=> $stable(nxt_insn_o)); // R2

    AST_ADV_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (skip_code_i == CODE_ADV) && !fill_o |=> cur_insn_o == $past(nxt_insn_o)); // R3

    AST_DELAYED_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (spec_code_i == CODE_DXFR) ##1 !fill_o |=> cur_insn_o == $past(nxt_insn_o)); // R4

    AST_FILL_OPND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fill_o |-> opnd_o == mem_word_i); // R6

    AST_FILL_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fill_o |=> (cur_insn_o == $past(mem_word_i)) && (nxt_insn_o == $past(mem_word_i))
                   && !nxt_full_o); // R6

    AST_OPND_CUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fill_o |-> opnd_o == cur_insn_o); // R7

    AST_RIGHT_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        right_op_i |-> xlat_cur_o); // R9
endmodule

bind insn_prefetch_pair ipf_checker #(
    .WORD_W(WORD_W), .FIELD_W(FIELD_W), .SPEC_W(SPEC_W),
    .CODE_ADV(CODE_ADV), .CODE_FNXT(CODE_FNXT), .CODE_DXFR(CODE_DXFR)
) u_ipf_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .mem_word_i(mem_word_i), .mem_valid_i(mem_valid_i),
    .skip_code_i(skip_code_i), .spec_code_i(spec_code_i), .mctl_code_i(mctl_code_i),
    .right_op_i(right_op_i), .cur_insn_o(cur_insn_o), .nxt_insn_o(nxt_insn_o),
    .opnd_o(opnd_o), .fill_o(fill_o), .nxt_full_o(nxt_full_o), .xlat_cur_o(xlat_cur_o)
);

// File: tb/insn_prefetch_pair_test.sv
`timescale 1ns/100ps
module insn_prefetch_pair_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mw = '0;
    logic        mv = 1'b0;
    logic [2:0]  sk = '0;
    logic [4:0]  sp = '0;
    logic [2:0]  mc = '0;
    logic        pe = 1'b0;
    logic        ro = 1'b0;
    logic [15:0] cur, nxt, opnd;
    logic        fill, full, xlat;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model state
    logic [15:0] m_cur = '0, m_nxt = '0;
    logic        m_full = 0, m_pend = 0;
    int          m_age = 2;

    always #2 clk = ~clk;

    insn_prefetch_pair uut (
        .clk_i(clk), .rst_ni(rst_n), .mem_word_i(mw), .mem_valid_i(mv),
        .skip_code_i(sk), .spec_code_i(sp), .mctl_code_i(mc), .pipe_empty_i(pe),
        .right_op_i(ro), .cur_insn_o(cur), .nxt_insn_o(nxt), .opnd_o(opnd),
        .fill_o(fill), .nxt_full_o(full), .xlat_cur_o(xlat)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_fill(input logic [2:0] s, input logic [2:0] m, input logic v, input logic p);
        bit xf = (s == 3'd5) || m_pend;
        bit ld = v && ((s == 3'd5) || (m == 3'd2));
        return xf && ld && (p || !m_full);
    endfunction

    // one cycle: drive at posedge+1, check combinational at negedge, registers after edge
    task automatic cyc(input logic [15:0] w, input logic v, input logic [2:0] s,
                       input logic [4:0] x, input logic [2:0] m, input logic p, input logic r);
        bit xf, ld, fl;
        logic [15:0] n_cur, n_nxt;
        logic n_full;
        mw = w; mv = v; sk = s; sp = x; mc = m; pe = p; ro = r;
        xf = (s == 3'd5) || m_pend;
        ld = v && ((s == 3'd5) || (m == 3'd2));
        fl = exp_fill(s, m, v, p);
        #1;
        chk("R6 fill", int'(fill), int'(fl));
        chk(fl ? "R6 opnd" : "R7 opnd", int'(opnd), int'(fl ? w : m_cur));
        chk("R9 xlat", int'(xlat), int'(r || m_age >= 2));
        n_cur = m_cur; n_nxt = m_nxt; n_full = m_full;
        if (fl) begin
            n_cur = w; n_nxt = w; n_full = 0;
        end else begin
            if (xf) begin n_cur = m_nxt; n_full = 0; end
            if (ld) begin n_nxt = w; n_full = 1; end
        end
        @(posedge clk); #1;
        m_cur = n_cur; m_nxt = n_nxt; m_full = n_full;
        m_pend = (x == 5'd9);
        m_age = xf ? 0 : ((m_age < 2) ? m_age + 1 : 2);
        chk("R3 cur", int'(cur), int'(m_cur));
        chk("R2 nxt", int'(nxt), int'(m_nxt));
        chk("R8 full", int'(full), int'(m_full));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 cur", int'(cur), 0);
        chk("R1 nxt", int'(nxt), 0);
        chk("R1 full", int'(full), 0);
        chk("R1 xlat", int'(xlat), 1);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R10: foreign codes and load code without valid leave registers alone
        cyc(16'hAAAA, 1, 3'd3, 5'd8, 3'd6, 0, 0);
        chk("R10 nxt", int'(nxt), 0);
        cyc(16'hBBBB, 0, 3'd0, 5'd0, 3'd2, 0, 0);
        chk("R10 full", int'(full), 0);

        // R2/R8: fetch-next load without transfer
        cyc(16'h1234, 1, 3'd0, 5'd0, 3'd2, 0, 0);
        chk("R2 load", int'(nxt), 16'h1234);
        chk("R8 set", int'(full), 1);

        // R5: load and advance together, pipeline full
        cyc(16'h5678, 1, 3'd5, 5'd0, 3'd0, 0, 0);
        chk("R5 cur", int'(cur), 16'h1234);
        chk("R5 nxt", int'(nxt), 16'h5678);
        chk("R5 full", int'(full), 1);

        // R4: delayed special transfer
        cyc(16'h0000, 0, 3'd0, 5'd9, 3'd0, 0, 0);
        chk("R4 not yet", int'(cur), 16'h1234);
        cyc(16'h0000, 0, 3'd0, 5'd0, 3'd0, 0, 0);
        chk("R4 moved", int'(cur), 16'h5678);
        chk("R8 clear", int'(full), 0);

        // R9: translation source ages back to current register
        cyc(16'h0, 0, 3'd0, 5'd0, 3'd0, 0, 0);
        cyc(16'h0, 0, 3'd0, 5'd0, 3'd0, 0, 0);

        // R6: fill with empty next register
        cyc(16'h9ABC, 1, 3'd5, 5'd0, 3'd0, 0, 0);
        chk("R6 cur", int'(cur), 16'h9ABC);
        // R6: fill forced by pipe-empty flag while next register is full
        cyc(16'h1111, 1, 3'd0, 5'd0, 3'd2, 0, 0);
        cyc(16'h2222, 1, 3'd5, 5'd0, 3'd0, 1, 1);
        chk("R6 forced", int'(cur), 16'h2222);

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] s, m;
            logic [4:0] x;
            s = ($urandom % 3 == 0) ? 3'd5 : 3'($urandom);
            m = ($urandom % 3 == 0) ? 3'd2 : 3'($urandom);
            x = ($urandom % 5 == 0) ? 5'd9 : 5'($urandom);
            cyc(16'($urandom), 1'($urandom % 4 != 0), s, x, m,
                1'($urandom % 6 == 0), 1'($urandom % 5 == 0));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule